// File: doc/BRIEF.md
# Multi-source NMI request controller

This block merges three non-maskable interrupt causes into one level request to a processor core. The three causes are a rising edge on an external interrupt pin, an oscillator failure indication and a flash access violation indication. Each cause has a sticky flag and an enable bit. The request stays high while any flagged cause is also enabled. When the core signals that it has taken the request, the block drops all three enables and the global interrupt enable in a single step. The handler therefore cannot be re-entered until software arms the enables again. Acceptance leaves the flags untouched, and software clears each one through the register port.

The block also gates the ordinary maskable requests, such as peripheral interrupts and a watchdog interval tick. Each maskable request passes only when its own enable bit is set and the global enable is set. The non-maskable path ignores the global enable.

Software reaches four registers over a synchronous write port with a combinational read port. Every write carries an operation code that loads, sets or clears individual bits.

Top module: `nmi_req_ctrl`

## Requirements
- R1: After reset, every flag, every NMI enable, every maskable enable and the global enable read as zero, and `nmi_req` and `irq_out` are low.
- R2: The external pin is synchronized through two flip-flops and then edge-detected. If the pin rises before clock edge E1, flag bit 0 reads 1 after edge E3 and not earlier. A pin held high does not set the flag again after software has cleared it.
- R3: A high `osc_fault` in a cycle sets flag bit 1 at the next edge. A high `flash_viol` in a cycle sets flag bit 2 at the next edge.
- R4: Flags are cleared only by a register write to address 0. `nmi_ack` does not change them.
- R5: When a source event and a software clear of the same flag fall in one cycle, the flag stays set.
- R6: `nmi_req` is high exactly when some flag bit and the enable at the same position are both 1. The global enable has no effect on it.
- R7: `nmi_ack` high in a cycle clears all three NMI enables and the global enable at the next edge. This takes priority over a write to those registers in the same cycle.
- R8: `irq_out[i]` equals `mask_req[i]` AND maskable enable bit i AND the global enable.
- R9: The register map is as follows. Address 0 holds the flags, with bit 0 for the pin, bit 1 for the oscillator and bit 2 for flash. Address 1 holds the NMI enables at the same positions. Address 2 holds the maskable enables. Address 3 bit 0 holds the global enable.
- R10: The write operation codes are 0 = load, 1 = set the bits that are 1 in the data and 2 = clear the bits that are 1 in the data. Code 3 changes nothing. Reads return the addressed register zero-extended.
- R11: Writing an enable back to 1 while its flag is still pending raises `nmi_req` after that write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | External NMI pin, asynchronous |
| osc_fault | input | 1 | Oscillator fault event, synchronous |
| flash_viol | input | 1 | Flash access violation event, synchronous |
| nmi_ack | input | 1 | Single-cycle NMI acceptance from the core |
| mask_req | input | NMASK | Maskable interrupt requests |
| bus_we | input | 1 | Register write strobe |
| bus_op | input | 2 | Write operation code |
| bus_addr | input | 2 | Register address for read and write |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` |
| nmi_req | output | 1 | Combined NMI request level |
| irq_out | output | NMASK | Gated maskable requests |

## Verification
The assertions assume that `osc_fault` and `flash_viol` are already synchronous to `clk`. They also assume that `nmi_ack` is a plain one-cycle strobe that the core may raise in any cycle, with or without a pending request. The sticky-flag property holds because the only clear path is a write strobe to address 0. The bench drives every input on the falling edge, and it keeps `nmi_ack` rare so that requests can build up between acceptances. Random writes cover all four operation codes and all four addresses, including writes that land in the same cycle as events and acceptances.

// File: rtl/nmi_req_pkg.sv
package nmi_req_pkg;

  localparam int NSRC = 3;

  localparam int SRC_PIN   = 0;
  localparam int SRC_OSC   = 1;
  localparam int SRC_FLASH = 2;

  localparam logic [1:0] ADDR_FLAG = 2'd0;
  localparam logic [1:0] ADDR_NEN  = 2'd1;
  localparam logic [1:0] ADDR_MEN  = 2'd2;
  localparam logic [1:0] ADDR_CTL  = 2'd3;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_NONE = 2'd3
  } bus_op_e;

  // Bit-wise register update for one write operation.
  function automatic logic [31:0] apply_op(bus_op_e op, logic [31:0] cur, logic [31:0] d);
    logic [31:0] r;
    case (op)
      OP_LOAD: r = d;
      OP_SET:  r = cur | d;
      OP_CLR:  r = cur & ~d;
      default: r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/nmi_pin_sync.sv
module nmi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_rise
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= pin_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  assign pin_rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/nmi_src_bank.sv
module nmi_src_bank
  import nmi_req_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_evt,
  input  logic            flag_wr,
  input  logic            en_wr,
  input  bus_op_e         op,
  input  logic [NSRC-1:0] wdata,
  input  logic            ack,
  output logic [NSRC-1:0] flag_q,
  output logic [NSRC-1:0] en_q,
  output logic            req
);

  logic [NSRC-1:0] flag_d;
  logic [NSRC-1:0] en_d;
  logic [31:0]     flag_upd;
  logic [31:0]     en_upd;

  always_comb begin
    flag_upd = apply_op(op, 32'(flag_q), 32'(wdata));
    en_upd   = apply_op(op, 32'(en_q), 32'(wdata));
    // Software write first, then events win over any clear.
    flag_d = flag_wr ? flag_upd[NSRC-1:0] : flag_q;
    flag_d = flag_d | src_evt;
    // Acceptance overrides a same-cycle enable write.
    if (ack)        en_d = '0;
    else if (en_wr) en_d = en_upd[NSRC-1:0];
    else            en_d = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
    end
  end

  assign req = |(flag_q & en_q);

endmodule

// File: rtl/nmi_mask_gate.sv
module nmi_mask_gate
  import nmi_req_pkg::*;
#(
  parameter int NMASK = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             men_wr,
  input  logic             gie_wr,
  input  bus_op_e          op,
  input  logic [NMASK-1:0] wdata,
  input  logic             ack,
  input  logic [NMASK-1:0] mask_req,
  output logic [NMASK-1:0] men_q,
  output logic             gie_q,
  output logic [NMASK-1:0] irq_out
);

  logic [31:0] men_upd;
  logic [31:0] gie_upd;
  logic [NMASK-1:0] men_d;
  logic gie_d;

  always_comb begin
    men_upd = apply_op(op, 32'(men_q), 32'(wdata));
    gie_upd = apply_op(op, 32'(gie_q), 32'(wdata[0]));
    men_d   = men_wr ? men_upd[NMASK-1:0] : men_q;
    if (ack)         gie_d = 1'b0;
    else if (gie_wr) gie_d = gie_upd[0];
    else             gie_d = gie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      men_q <= '0;
      gie_q <= 1'b0;
    end else begin
      men_q <= men_d;
      gie_q <= gie_d;
    end
  end

  genvar i;
  generate
    for (i = 0; i < NMASK; i++) begin : g_gate
      assign irq_out[i] = mask_req[i] & men_q[i] & gie_q;
    end
  endgenerate

endmodule

// File: rtl/nmi_req_ctrl.sv
module nmi_req_ctrl
  import nmi_req_pkg::*;
#(
  parameter int NMASK       = 4,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_pin,
  input  logic             osc_fault,
  input  logic             flash_viol,
  input  logic             nmi_ack,
  input  logic [NMASK-1:0] mask_req,
  input  logic             bus_we,
  input  logic [1:0]       bus_op,
  input  logic [1:0]       bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             nmi_req,
  output logic [NMASK-1:0] irq_out
);

  bus_op_e          op;
  logic             wr_active;
  logic             flag_wr_ev;
  logic             nen_wr_ev;
  logic             men_wr_ev;
  logic             gie_wr_ev;
  logic             pin_rise;
  logic [NSRC-1:0]  src_evt;
  logic [NSRC-1:0]  flag_q;
  logic [NSRC-1:0]  en_q;
  logic [NMASK-1:0] men_q;
  logic             gie_q;

  assign op         = bus_op_e'(bus_op);
  assign wr_active  = bus_we && (op != OP_NONE);
  assign flag_wr_ev = wr_active && (bus_addr == ADDR_FLAG);
  assign nen_wr_ev  = wr_active && (bus_addr == ADDR_NEN);
  assign men_wr_ev  = wr_active && (bus_addr == ADDR_MEN);
  assign gie_wr_ev  = wr_active && (bus_addr == ADDR_CTL);

  nmi_pin_sync #(.STAGES(SYNC_STAGES)) u_pin (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (nmi_pin),
    .pin_rise  (pin_rise)
  );

  always_comb begin
    src_evt            = '0;
    src_evt[SRC_PIN]   = pin_rise;
    src_evt[SRC_OSC]   = osc_fault;
    src_evt[SRC_FLASH] = flash_viol;
  end

  nmi_src_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_evt (src_evt),
    .flag_wr (flag_wr_ev),
    .en_wr   (nen_wr_ev),
    .op      (op),
    .wdata   (bus_wdata[NSRC-1:0]),
    .ack     (nmi_ack),
    .flag_q  (flag_q),
    .en_q    (en_q),
    .req     (nmi_req)
  );

  nmi_mask_gate #(.NMASK(NMASK)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .men_wr   (men_wr_ev),
    .gie_wr   (gie_wr_ev),
    .op       (op),
    .wdata    (bus_wdata[NMASK-1:0]),
    .ack      (nmi_ack),
    .mask_req (mask_req),
    .men_q    (men_q),
    .gie_q    (gie_q),
    .irq_out  (irq_out)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_FLAG: bus_rdata[NSRC-1:0]  = flag_q;
      ADDR_NEN:  bus_rdata[NSRC-1:0]  = en_q;
      ADDR_MEN:  bus_rdata[NMASK-1:0] = men_q;
      default:   bus_rdata[0]         = gie_q;
    endcase
  end

endmodule

// File: rtl/nmi_req_ctrl_chk.sv
module nmi_req_ctrl_chk #(
  parameter int NMASK = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             nmi_ack,
  input logic             osc_fault,
  input logic             flash_viol,
  input logic [2:0]       flag_q,
  input logic [2:0]       en_q,
  input logic             gie_q,
  input logic             flag_wr_ev,
  input logic             nmi_req,
  input logic [NMASK-1:0] irq_out
);

  // R7: acceptance removes the request and the global enable
  p_ack_drops_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_ack |=> !nmi_req);
  p_ack_clears_gie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_ack |=> !gie_q);

  // R8: nothing maskable passes without the global enable
  p_gie_gates_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |-> (irq_out == '0));

  // R3: events set their flags
  p_osc_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    osc_fault |=> flag_q[1]);
  p_flash_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flash_viol |=> flag_q[2]);

  // R4: a flag falls only after a flag-register write
  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(flag_q) & ~flag_q)) |-> $past(flag_wr_ev));

  // R6: a request needs some enable
  p_req_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> (|en_q));

endmodule

bind nmi_req_ctrl nmi_req_ctrl_chk #(.NMASK(NMASK)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .nmi_ack    (nmi_ack),
  .osc_fault  (osc_fault),
  .flash_viol (flash_viol),
  .flag_q     (flag_q),
  .en_q       (en_q),
  .gie_q      (gie_q),
  .flag_wr_ev (flag_wr_ev),
  .nmi_req    (nmi_req),
  .irq_out    (irq_out)
);

// File: tb/nmi_req_ctrl_tb.sv
module nmi_req_ctrl_tb;

  localparam int NMASK = 4;
  localparam int DW    = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             nmi_pin = 1'b0;
  logic             osc_fault = 1'b0;
  logic             flash_viol = 1'b0;
  logic             nmi_ack = 1'b0;
  logic [NMASK-1:0] mask_req = '0;
  logic             bus_we = 1'b0;
  logic [1:0]       bus_op = 2'd0;
  logic [1:0]       bus_addr = 2'd0;
  logic [DW-1:0]    bus_wdata = '0;
  logic [DW-1:0]    bus_rdata;
  logic             nmi_req;
  logic [NMASK-1:0] irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model of the register state
  logic [2:0]       m_flag = '0, m_en = '0;
  logic [NMASK-1:0] m_men = '0;
  logic             m_gie = 1'b0;
  logic             m_s1 = 1'b0, m_s2 = 1'b0, m_s3 = 1'b0;

  always #2.5 clk = ~clk;

  nmi_req_ctrl #(.NMASK(NMASK), .DW(DW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .osc_fault(osc_fault),
    .flash_viol(flash_viol), .nmi_ack(nmi_ack), .mask_req(mask_req),
    .bus_we(bus_we), .bus_op(bus_op), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nmi_req(nmi_req),
    .irq_out(irq_out)
  );

  function automatic logic [7:0] upd(logic [1:0] op, logic [7:0] cur, logic [7:0] d);
    if (op == 2'd0) return d;
    if (op == 2'd1) return cur | d;
    if (op == 2'd2) return cur & ~d;
    return cur;
  endfunction

  function automatic logic [7:0] model_read(logic [1:0] a);
    case (a)
      2'd0: return {5'b0, m_flag};
      2'd1: return {5'b0, m_en};
      2'd2: return {4'b0, m_men};
      default: return {7'b0, m_gie};
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // advance one clock with the current inputs, updating the model alongside
  task automatic step();
    logic [2:0] n_flag, n_en;
    logic [NMASK-1:0] n_men;
    logic n_gie, rise;
    logic [7:0] t;
    rise   = m_s2 & ~m_s3;
    n_flag = m_flag; n_en = m_en; n_men = m_men; n_gie = m_gie;
    if (bus_we) begin
      case (bus_addr)
        2'd0: begin t = upd(bus_op, {5'b0, m_flag}, bus_wdata); n_flag = t[2:0]; end
        2'd1: begin t = upd(bus_op, {5'b0, m_en}, bus_wdata);   n_en   = t[2:0]; end
        2'd2: begin t = upd(bus_op, {4'b0, m_men}, bus_wdata);  n_men  = t[3:0]; end
        default: begin t = upd(bus_op, {7'b0, m_gie}, {7'b0, bus_wdata[0]}); n_gie = t[0]; end
      endcase
    end
    n_flag = n_flag | {flash_viol, osc_fault, rise};
    if (nmi_ack) begin n_en = '0; n_gie = 1'b0; end
    @(posedge clk);
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = nmi_pin;
    m_flag = n_flag; m_en = n_en; m_men = n_men; m_gie = n_gie;
    @(negedge clk);
  endtask

  task automatic check_outputs();
    check(nmi_req == |(m_flag & m_en), "R6", 32'(nmi_req), 32'(|(m_flag & m_en)));
    check(irq_out == (mask_req & m_men & {NMASK{m_gie}}), "R8",
          32'(irq_out), 32'(mask_req & m_men & {NMASK{m_gie}}));
  endtask

  task automatic idle();
    bus_we = 1'b0; nmi_ack = 1'b0; osc_fault = 1'b0; flash_viol = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [1:0] op, logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_op = op; bus_wdata = d;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    bus_we = 1'b0; bus_addr = a;
    #0.5 v = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check(v == 8'h00, "R1", 32'(v), 0);
    end
    check(nmi_req == 1'b0 && irq_out == '0, "R1", 32'({nmi_req, irq_out}), 0);

    // R2: synchronizer latency, edge only
    nmi_pin = 1'b1;
    step(); step();
    rd(2'd0, v);
    check(v[0] == 1'b0, "R2 early", 32'(v), 0);
    step();
    rd(2'd0, v);
    check(v[0] == 1'b1, "R2 latency", 32'(v), 1);
    wr(2'd0, 2'd2, 8'h01); step(); idle();
    step(); step(); step();
    rd(2'd0, v);
    check(v[0] == 1'b0, "R2 held pin", 32'(v), 0);

    // R3 and R5: flash event beats a same-cycle clear
    flash_viol = 1'b1; step();
    flash_viol = 1'b1; wr(2'd0, 2'd2, 8'h04); step(); idle();
    rd(2'd0, v);
    check(v == 8'h04, "R5", 32'(v), 4);
    osc_fault = 1'b1; step(); idle();
    rd(2'd0, v);
    check(v == 8'h06, "R3 osc", 32'(v), 6);
    wr(2'd0, 2'd2, 8'h02); step(); idle();

    // R6: request independent of global enable (GIE still 0)
    wr(2'd1, 2'd0, 8'h07); step(); idle();
    check(nmi_req == 1'b1, "R6", 32'(nmi_req), 1);

    // R7 and R4: acceptance beats a same-cycle enable write, flags kept
    wr(2'd3, 2'd1, 8'h01); step(); idle();
    nmi_ack = 1'b1; wr(2'd1, 2'd0, 8'h07); step(); idle();
    check(nmi_req == 1'b0, "R7 req", 32'(nmi_req), 0);
    rd(2'd1, v); check(v == 8'h00, "R7 en", 32'(v), 0);
    rd(2'd3, v); check(v == 8'h00, "R7 gie", 32'(v), 0);
    rd(2'd0, v); check(v == 8'h04, "R4", 32'(v), 4);

    // R11: re-arm with pending flag
    wr(2'd1, 2'd1, 8'h04); step(); idle();
    check(nmi_req == 1'b1, "R11", 32'(nmi_req), 1);

    // R10: op code 3 has no effect
    wr(2'd0, 2'd3, 8'h00); step(); idle();
    rd(2'd0, v); check(v == 8'h04, "R10 nop", 32'(v), 4);

    // R8: maskable gating
    mask_req = 4'b1011;
    wr(2'd2, 2'd0, 8'h0F); step(); idle();
    check(irq_out == 4'b0000, "R8 gie off", 32'(irq_out), 0);
    wr(2'd3, 2'd0, 8'h01); step(); idle();
    check(irq_out == 4'b1011, "R8 gie on", 32'(irq_out), 32'hB);
    wr(2'd2, 2'd2, 8'h02); step(); idle();
    check(irq_out == 4'b1001, "R8 per-bit", 32'(irq_out), 9);

    // random phase: R6 R8 R9 R10 against the bench model
    for (int n = 0; n < 3000; n++) begin
      check_outputs();
      if (($urandom % 8) == 0) nmi_pin = ~nmi_pin;
      osc_fault  = (($urandom % 16) == 0);
      flash_viol = (($urandom % 16) == 0);
      nmi_ack    = (($urandom % 20) == 0);
      mask_req   = NMASK'($urandom);
      bus_we     = (($urandom % 3) == 0);
      bus_op     = 2'($urandom);
      bus_addr   = 2'($urandom);
      bus_wdata  = 8'($urandom);
      #0.5;
      check(bus_rdata == model_read(bus_addr), "R9 R10 read",
            32'(bus_rdata), 32'(model_read(bus_addr)));
      step();
    end
    idle();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule